// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides, bus clock by bus clock, whether the CPU or one of four DMA channels owns the system bus. Each channel keeps one pending flag. A request pulse on an enabled channel sets that flag, and several pulses before service still count as one. When the CPU holds the bus, has finished at least one access since the last DMA transfer, and any flag is set, the lowest-numbered pending channel takes the bus for exactly one transfer. Its flag clears on that same edge.

The length of the transfer comes from the granted channel's attributes: transfer width, the parity of its source and destination addresses, and whether each side lies in the special-register region. At the end of the transfer the bus goes back to the CPU and a one-cycle done pulse is issued. The block also watches the spacing between requests on each channel against a limit that grows with the number of enabled channels, and reports any request that arrives too soon.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, `gnt_cpu` is 1, `gnt_ch`, `xfer_done` and `spacing_err` are 0, and no channel is pending.
- R2: When several channels are pending, grants go out in index order, lowest first: channel 0, then 1, then 2, then 3. Each grant is preceded by one CPU access.
- R3: A channel has a single pending flag. Any number of request pulses before its grant yield exactly one transfer.
- R4: A pending flag clears on the edge that grants its channel. A request sampled on that same edge is kept as a new pending request and leads to a second transfer.
- R5: After a DMA transfer the CPU keeps the bus until a cycle with `cpu_done`=1. A pending channel is granted on that edge, so `gnt_ch` is visible in the following cycle. Control never passes directly from one channel to another. Right after reset no CPU access is needed.
- R6: `gnt_ch` stays high for D = R·j + W·k cycles. R (W) is 2 when `cfg_wide`=1 and `src_odd` (`dst_odd`) is 1, and 1 otherwise. j (k) is 2 when `src_sfr` (`dst_sfr`) is 1, and 1 otherwise. All bits are taken from the granted channel's index.
- R7: `xfer_done` is high for exactly one cycle: the first cycle in which `gnt_cpu` is back at 1 after a channel grant.
- R8: While `ch_en[i]`=0, requests on channel i are dropped and its pending flag is held clear. Enabling the channel later does not revive them.
- R9: Exactly one of `gnt_cpu` and the bits of `gnt_ch` is 1 in every cycle.
- R10: Let the limit L be (number of enabled channels − 1) × 5 cycles. A request on an enabled channel that arrives fewer than L cycles after that channel's previous request raises `spacing_err[i]` for one cycle, in the cycle after that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | 4 | Per-channel request pulses |
| ch_en | input | 4 | Per-channel enable |
| cfg_wide | input | 4 | Per-channel 16-bit transfer select |
| src_odd | input | 4 | Per-channel odd source address |
| dst_odd | input | 4 | Per-channel odd destination address |
| src_sfr | input | 4 | Per-channel source in special-register region |
| dst_sfr | input | 4 | Per-channel destination in special-register region |
| cpu_done | input | 1 | CPU finished one bus access |
| gnt_cpu | output | 1 | CPU owns the bus |
| gnt_ch | output | 4 | One-hot channel grant |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| spacing_err | output | 4 | Per-channel request-spacing violation pulse |

## Verification
The critical overlap is a grant clearing a channel's pending flag on the same edge that samples a fresh request for that channel. The bench provokes it by holding a request for two cycles, so the second cycle coincides with the grant edge. The overlap is judged correct only if a second, separate transfer of that channel follows the next CPU access, and no third transfer appears after it. The bench also sweeps every attribute combination on every channel and compares each grant length with the arithmetic of R6.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int DUR_W = 4;

  typedef enum logic [0:0] {OWN_CPU, OWN_DMA} owner_e;

  typedef struct packed {
    logic wide;
    logic src_odd;
    logic dst_odd;
    logic src_sfr;
    logic dst_sfr;
  } xfer_attr_t;

  // read cycles times region factor plus write cycles times region factor
  function automatic logic [DUR_W-1:0] xfer_cycles(input xfer_attr_t a);
    logic [DUR_W-1:0] rd;
    logic [DUR_W-1:0] wr;
    rd = (a.wide && a.src_odd) ? DUR_W'(2) : DUR_W'(1);
    wr = (a.wide && a.dst_odd) ? DUR_W'(2) : DUR_W'(1);
    if (a.src_sfr) rd = rd << 1;
    if (a.dst_sfr) wr = wr << 1;
    return rd + wr;
  endfunction

endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch #(
  parameter int NCH      = 4,
  parameter int GAP_UNIT = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] gap_err
);

  localparam int MAXGAP = (NCH - 1) * GAP_UNIT;
  localparam int CW     = $clog2(MAXGAP + 1) + 1;

  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] err_q;
  logic [CW-1:0]  gap_lim;
  logic [NCH-1:0] hit;

  assign hit = req & en;

  always_comb begin
    int nen;
    nen = $countones(en);
    gap_lim = (nen == 0) ? '0 : CW'((nen - 1) * GAP_UNIT);
  end

  // a new request wins over the clear of a grant on the same edge
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= ((pend_q & ~clr) | hit) & en;
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_gap
      logic [CW-1:0] since_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          since_q  <= '1;
          err_q[i] <= 1'b0;
        end else begin
          err_q[i] <= hit[i] && (since_q < gap_lim);
          if (hit[i])             since_q <= CW'(1);
          else if (since_q != '1) since_q <= since_q + CW'(1);
        end
      end
    end
  endgenerate

  assign pend    = pend_q;
  assign gap_err = err_q;

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH   = 4,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   cand,
  output logic             any,
  output logic [NCH-1:0]   sel,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    logic taken;
    taken = 1'b0;
    sel   = '0;
    idx   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cand[i] && !taken) begin
        sel[i] = 1'b1;
        idx    = IDX_W'(i);
        taken  = 1'b1;
      end
    end
    any = taken;
  end

endmodule

// File: rtl/dma_xfer_timer.sv
module dma_xfer_timer
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DUR_W-1:0] dur,
  output logic             last
);

  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (start)          cnt_q <= dur - DUR_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - DUR_W'(1);
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int GAP_UNIT = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ch_req,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] cfg_wide,
  input  logic [NCH-1:0] src_odd,
  input  logic [NCH-1:0] dst_odd,
  input  logic [NCH-1:0] src_sfr,
  input  logic [NCH-1:0] dst_sfr,
  input  logic           cpu_done,
  output logic           gnt_cpu,
  output logic [NCH-1:0] gnt_ch,
  output logic           xfer_done,
  output logic [NCH-1:0] spacing_err
);

  localparam int IDX_W = $clog2(NCH);

  owner_e           owner_q;
  logic             cpu_seen_q;
  logic             gnt_cpu_q;
  logic [NCH-1:0]   gnt_ch_q;
  logic             done_q;

  logic [NCH-1:0]   pend;
  logic             any;
  logic [NCH-1:0]   sel;
  logic [IDX_W-1:0] idx;
  logic             grant_go;
  logic             end_go;
  logic             last;
  logic [NCH-1:0]   clr;
  xfer_attr_t       attr;

  dma_req_latch #(.NCH(NCH), .GAP_UNIT(GAP_UNIT)) u_latch (
    .clk(clk), .rst(rst), .req(ch_req), .en(ch_en), .clr(clr),
    .pend(pend), .gap_err(spacing_err)
  );

  dma_prio_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
    .cand(pend & ch_en), .any(any), .sel(sel), .idx(idx)
  );

  always_comb begin
    attr.wide    = cfg_wide[idx];
    attr.src_odd = src_odd[idx];
    attr.dst_odd = dst_odd[idx];
    attr.src_sfr = src_sfr[idx];
    attr.dst_sfr = dst_sfr[idx];
  end

  assign grant_go = (owner_q == OWN_CPU) && (cpu_seen_q || cpu_done) && any;
  assign end_go   = (owner_q == OWN_DMA) && last;
  assign clr      = grant_go ? sel : '0;

  dma_xfer_timer u_timer (
    .clk(clk), .rst(rst), .start(grant_go), .dur(xfer_cycles(attr)), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q    <= OWN_CPU;
      cpu_seen_q <= 1'b1;
      gnt_cpu_q  <= 1'b1;
      gnt_ch_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= end_go;
      if (grant_go) begin
        owner_q    <= OWN_DMA;
        gnt_ch_q   <= sel;
        gnt_cpu_q  <= 1'b0;
        cpu_seen_q <= 1'b0;
      end else if (end_go) begin
        owner_q   <= OWN_CPU;
        gnt_ch_q  <= '0;
        gnt_cpu_q <= 1'b1;
      end else if (owner_q == OWN_CPU && cpu_done) begin
        cpu_seen_q <= 1'b1;
      end
    end
  end

  assign gnt_cpu   = gnt_cpu_q;
  assign gnt_ch    = gnt_ch_q;
  assign xfer_done = done_q;

endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] ch_en,
  input logic           gnt_cpu,
  input logic [NCH-1:0] gnt_ch,
  input logic           xfer_done
);

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({gnt_ch, gnt_cpu}) == 1);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  // R7
  done_after_dma_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (gnt_cpu && $past(|gnt_ch)));

  // R5
  no_direct_handoff_chk: assert property (@(posedge clk) disable iff (rst)
    (|gnt_ch) |=> ((gnt_ch == $past(gnt_ch)) || gnt_cpu));

  // R8
  enabled_grant_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(gnt_cpu) && (|gnt_ch)) |-> (|(gnt_ch & $past(ch_en))));

endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .ch_en(ch_en), .gnt_cpu(gnt_cpu),
  .gnt_ch(gnt_ch), .xfer_done(xfer_done)
);

// File: tb/sim_dma_bus_arbiter.sv
module sim_dma_bus_arbiter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ch_req = '0, ch_en = 4'hF;
  logic [3:0] cfg_wide = '0, src_odd = '0, dst_odd = '0, src_sfr = '0, dst_sfr = '0;
  logic       cpu_done = 1'b0;
  logic       gnt_cpu, xfer_done;
  logic [3:0] gnt_ch, spacing_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_bus_arbiter u0 (
    .clk(clk), .rst(rst), .ch_req(ch_req), .ch_en(ch_en), .cfg_wide(cfg_wide),
    .src_odd(src_odd), .dst_odd(dst_odd), .src_sfr(src_sfr), .dst_sfr(dst_sfr),
    .cpu_done(cpu_done), .gnt_cpu(gnt_cpu), .gnt_ch(gnt_ch),
    .xfer_done(xfer_done), .spacing_err(spacing_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_req(input logic [3:0] m);
    ch_req = m; step(); ch_req = '0;
  endtask

  task automatic pulse_cpu();
    cpu_done = 1'b1; step(); cpu_done = 1'b0;
  endtask

  // waits for a grant, reports who, how long it lasted and the wait
  task automatic measure(output logic [3:0] who, output int len, output int waited);
    int w = 0;
    int n = 0;
    while (gnt_ch == 4'h0 && w < 30) begin step(); w++; end
    who = gnt_ch;
    while (gnt_ch == who && who != 4'h0 && n < 30) begin n++; step(); end
    len = n;
    waited = w;
    if (who != 4'h0) begin
      chk(xfer_done == 1'b1 && gnt_cpu == 1'b1, "R7 done pulse", int'(xfer_done), 1);
      step();
      chk(xfer_done == 1'b0, "R7 done width", int'(xfer_done), 0);
    end
  endtask

  task automatic idle_check(input int cycles, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (gnt_ch != 4'h0 || gnt_cpu != 1'b1) ok = 1'b0;
    end
    chk(ok, tag, int'(gnt_ch), 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] who;
    int len, w;

    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(gnt_cpu == 1'b1 && gnt_ch == 4'h0, "R1 grants", int'(gnt_ch), 0);
    chk(xfer_done == 1'b0 && spacing_err == 4'h0, "R1 pulses", int'(spacing_err), 0);
    idle_check(4, "R1 nothing pending");

    // R6 sweep: every attribute combination on every channel
    for (int ch = 0; ch < 4; ch++) begin
      for (int c = 0; c < 32; c++) begin
        int rd, wr, exp;
        logic [3:0] m;
        m = 4'(1 << ch);
        cfg_wide = c[0] ? m : ~m;
        src_odd  = c[1] ? m : ~m;
        dst_odd  = c[2] ? m : ~m;
        src_sfr  = c[3] ? m : ~m;
        dst_sfr  = c[4] ? m : ~m;
        rd = (c[0] && c[1]) ? 2 : 1;
        wr = (c[0] && c[2]) ? 2 : 1;
        if (c[3]) rd = rd * 2;
        if (c[4]) wr = wr * 2;
        exp = rd + wr;
        pulse_req(m);
        measure(who, len, w);
        chk(who == m, "R6 granted channel", int'(who), int'(m));
        chk(len == exp, "R6 duration", len, exp);
        pulse_cpu();
      end
    end
    cfg_wide = '0; src_odd = '0; dst_odd = '0; src_sfr = '0; dst_sfr = '0;

    // R2 / R5: one transfer, then all four pending behind the CPU
    pulse_req(4'h1);
    measure(who, len, w);
    pulse_req(4'hF);
    idle_check(6, "R5 waits for CPU access");
    for (int k = 0; k < 4; k++) begin
      pulse_cpu();
      chk(gnt_ch == 4'(1 << k), "R5 grant right after cpu_done", int'(gnt_ch), 1 << k);
      measure(who, len, w);
      chk(who == 4'(1 << k), "R2 priority order", int'(who), 1 << k);
    end
    pulse_cpu();
    idle_check(6, "R2 queue drained");

    // R3: repeated requests collapse
    pulse_req(4'h4);
    measure(who, len, w);
    pulse_req(4'h8); step(); pulse_req(4'h8); step(); pulse_req(4'h8);
    pulse_cpu();
    measure(who, len, w);
    chk(who == 4'h8, "R3 single transfer channel", int'(who), 8);
    pulse_cpu();
    idle_check(8, "R3 no second transfer");

    // R4: request on the grant edge is kept
    ch_req = 4'h2; step(); step(); ch_req = 4'h0;
    chk(gnt_ch == 4'h2, "R4 first grant", int'(gnt_ch), 2);
    measure(who, len, w);
    pulse_cpu();
    measure(who, len, w);
    chk(who == 4'h2, "R4 re-latched request served", int'(who), 2);
    pulse_cpu();
    idle_check(8, "R4 only two transfers");

    // R8: disabled channel ignores requests
    ch_en = 4'h7;
    pulse_req(4'h8);
    idle_check(6, "R8 disabled request ignored");
    ch_en = 4'hF;
    idle_check(6, "R8 not revived on enable");

    // R10: spacing limit with four enabled channels (15 cycles)
    repeat (20) step();
    pulse_req(4'h8);
    repeat (14) step();
    pulse_req(4'h8);
    chk(spacing_err[3] == 1'b0, "R10 interval 15 accepted", int'(spacing_err[3]), 0);
    repeat (20) step();
    pulse_req(4'h8);
    repeat (13) step();
    pulse_req(4'h8);
    chk(spacing_err == 4'h8, "R10 interval 14 flagged", int'(spacing_err), 8);
    step();
    chk(spacing_err == 4'h0, "R10 flag one cycle", int'(spacing_err), 0);
    // two enabled channels: limit 5
    ch_en = 4'h9;
    repeat (20) step();
    pulse_req(4'h8);
    repeat (3) step();
    pulse_req(4'h8);
    chk(spacing_err[3] == 1'b1, "R10 interval 4 flagged", int'(spacing_err[3]), 1);
    repeat (20) step();
    pulse_req(4'h8);
    repeat (4) step();
    pulse_req(4'h8);
    chk(spacing_err[3] == 1'b0, "R10 interval 5 accepted", int'(spacing_err[3]), 0);

    repeat (4) begin pulse_cpu(); repeat (10) step(); end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule